// File: doc/BRIEF.md
# Three-Channel Compare Timer

A register-mapped 32-bit up-counting timer for general system timing. Software picks one of three single-cycle tick enables as the time base, divides it with a 12-bit prescaler, and lets the counter run in one of two modes. In restart mode the counter wraps to zero right after it has matched compare channel 1. In free-run mode it covers the whole range and wraps from all-ones to zero.

Three compare channels and the wrap event each set a sticky status flag. A per-flag enable mask, together with the timer enable, drives one level interrupt. A self-clearing soft-reset bit returns the block to its reset state but keeps the enable, mode and clock-select settings of the control register. The two capture registers exist in the map and always read zero.

Top module: `gp_timer`

## Requirements
- R1: Word offsets: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2, 9 counter. Any other offset reads 0. Reads are combinational while `rd_i` is high. After reset every register reads 0, except the compare registers, which read all-ones.
- R2: Control bits 2, 4, 10, 11, 12, 13, 14 and the soft-reset bit 15 always read 0. All other written control bits read back as written. Bit 0 is enable, bit 1 is enable-mode, bits 8:6 are clock select and bit 9 is free-run.
- R3: The prescaler keeps its low 12 bits. While enabled, the counter advances once every (prescaler+1) ticks of the selected source.
- R4: Clock select 001 picks `tick_bus_i`, 010 picks `tick_fast_i`, and 100 through 111 pick `tick_slow_i`. Values 000 and 011 pick nothing, and the counter holds.
- R5: The status register holds six sticky flags. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A flag set by the counter in the same cycle as a clear of that flag stays set.
- R6: The interrupt enable register keeps its low 6 bits. `irq_o` is high exactly when (status AND enable) is nonzero and control bit 0 is set.
- R7: When the counter steps onto the value of compare register k, status bit k-1 is set (bits 0, 1, 2).
- R8: In restart mode (bit 9 clear), the counter returns to 0 on the step after it matches compare 1. Writing compare 1 in restart mode restarts the count from 0.
- R9: In free-run mode the counter steps from all-ones to 0 and sets status bit 5.
- R10: A control write that takes bit 0 from 0 to 1 with bit 1 set clears the counter and the prescale phase. With bit 1 clear, the count continues from where it stopped. While bit 0 is clear, the counter is frozen.
- R11: A control write with bit 15 set resets the block as in R1. Control bits 0, 1, 3, 5, 8:6, 16 and 17 take the written value and all other control bits are cleared.
- R12: Capture registers read 0, and status bits 3 and 4 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word offset of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe, gates `rdata_o` |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| tick_bus_i | input | 1 | Bus-clock tick enable |
| tick_fast_i | input | 1 | High-frequency tick enable |
| tick_slow_i | input | 1 | Slow tick enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The cycle checks cover these behaviours on every cycle: the counter stays still while disabled, flags stay set without a write, the interrupt is masked by the enable bit, the wrap in both modes happens where it should, and the unstored control bits and capture flags stay zero. Some behaviours show only in the bench scenarios. These are the clock-source decoding, the exact division by the prescaler, the set-over-clear priority, the restart caused by a compare-1 write, and the soft-reset preserve mask. The bench sweeps all eight select codes against each tick source and several prescale values, using a counter narrowed to 8 bits so that wrap is reachable.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_CMP = 3;
  localparam int unsigned NUM_FLG = 6;

  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_PRE  = 1;
  localparam int unsigned OFF_STAT = 2;
  localparam int unsigned OFF_IEN  = 3;
  localparam int unsigned OFF_CMP1 = 4;
  localparam int unsigned OFF_CNT  = 9;

  localparam int unsigned C_EN     = 0;
  localparam int unsigned C_ENMOD  = 1;
  localparam int unsigned C_SEL_LO = 6;
  localparam int unsigned C_FRR    = 9;
  localparam int unsigned C_SWR    = 15;

  localparam logic [31:0] CTRL_VOID = 32'h0000_FC14; // never stored (incl. soft reset)
  localparam logic [31:0] CTRL_KEEP = 32'h0003_01EB; // survive soft reset

  localparam int unsigned F_ROV = 5;

  typedef enum logic [1:0] {SRC_NONE, SRC_BUS, SRC_FAST, SRC_SLOW} src_e;

  function automatic src_e src_decode(input logic [2:0] sel);
    if (sel[2])          return SRC_SLOW;
    else if (sel == 3'd1) return SRC_BUS;
    else if (sel == 3'd2) return SRC_FAST;
    else                  return SRC_NONE;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             step_o
);
  logic [PRE_W-1:0] phase_q;

  // >= keeps the divider sane when div_i drops below the running phase
  assign step_o = run_i & tick_i & (phase_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (clr_i)            phase_q <= '0;
    else if (run_i && tick_i)  phase_q <= step_o ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_CMP = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic                            step_i,
  input  logic                            restart_i,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_i,
  output logic [CNT_W-1:0]                cnt_o,
  output logic [NUM_CMP-1:0]              hit_o,
  output logic                            wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             at_top, at_lim;

  assign at_top  = &cnt_q;
  assign at_lim  = restart_i && (cnt_q == cmp_i[0]);
  assign cnt_nxt = (at_top || at_lim) ? '0 : cnt_q + 1'b1;
  assign wrap_o  = step_i && at_top;
  assign cnt_o   = cnt_q;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_hit
    assign hit_o[k] = step_i && (cnt_nxt == cmp_i[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_bus_i,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] VOID_M = DATA_W'(CTRL_VOID);
  localparam logic [DATA_W-1:0] KEEP_M = DATA_W'(CTRL_KEEP);

  logic [DATA_W-1:0]              ctrl_q;
  logic [PRE_W-1:0]               pre_q;
  logic [NUM_FLG-1:0]             stat_q, ien_q, flg_set, flg_clr;
  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]               cnt_w;
  logic [NUM_CMP-1:0]             hit_w;
  logic                           wrap_w;

  logic wr_ctrl, wr_pre, wr_stat, wr_ien, wr_cmp1;
  logic swr, en_rise, cnt_clr, tick_sel, step_raw, step_eff;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl = wr_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_pre  = wr_i && (addr_i == ADDR_W'(OFF_PRE));
  assign wr_stat = wr_i && (addr_i == ADDR_W'(OFF_STAT));
  assign wr_ien  = wr_i && (addr_i == ADDR_W'(OFF_IEN));
  assign wr_cmp1 = wr_i && (addr_i == ADDR_W'(OFF_CMP1));

  assign swr     = wr_ctrl && wdata_i[C_SWR];
  assign en_rise = wr_ctrl && !swr && wdata_i[C_EN] && wdata_i[C_ENMOD] && !ctrl_q[C_EN];
  assign cnt_clr = swr || en_rise || (wr_cmp1 && !ctrl_q[C_FRR]);

  // control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (swr)     ctrl_q <= wdata_i & KEEP_M;
    else if (wr_ctrl) ctrl_q <= wdata_i & ~VOID_M;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (swr)    pre_q <= '0;
    else if (wr_pre) pre_q <= wdata_i[PRE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (swr)    ien_q <= '0;
    else if (wr_ien) ien_q <= wdata_i[NUM_FLG-1:0];
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic wr_k;
    assign wr_k = wr_i && (addr_i == ADDR_W'(OFF_CMP1 + k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cmp_q[k] <= '1;
      else if (swr)  cmp_q[k] <= '1;
      else if (wr_k) cmp_q[k] <= wdata_i[CNT_W-1:0];
    end
  end

  // status: set beats clear
  assign flg_set = {wrap_w, 2'b00, hit_w};
  assign flg_clr = wr_stat ? wdata_i[NUM_FLG-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  stat_q <= '0;
    else if (swr) stat_q <= '0;
    else          stat_q <= (stat_q & ~flg_clr) | flg_set;
  end

  // time base
  always_comb begin
    unique case (src_decode(ctrl_q[C_SEL_LO +: 3]))
      SRC_BUS:  tick_sel = tick_bus_i;
      SRC_FAST: tick_sel = tick_fast_i;
      SRC_SLOW: tick_sel = tick_slow_i;
      default:  tick_sel = 1'b0;
    endcase
  end

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .run_i  (ctrl_q[C_EN]),
    .tick_i (tick_sel),
    .div_i  (pre_q),
    .step_o (step_raw)
  );

  assign step_eff = step_raw && !cnt_clr;

  tmr_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cnt_clr),
    .step_i    (step_eff),
    .restart_i (!ctrl_q[C_FRR]),
    .cmp_i     (cmp_q),
    .cnt_o     (cnt_w),
    .hit_o     (hit_w),
    .wrap_o    (wrap_w)
  );

  // read path; capture offsets fall through to zero
  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(OFF_CTRL): rd_mux = ctrl_q;
      ADDR_W'(OFF_PRE):  rd_mux = DATA_W'(pre_q);
      ADDR_W'(OFF_STAT): rd_mux = DATA_W'(stat_q);
      ADDR_W'(OFF_IEN):  rd_mux = DATA_W'(ien_q);
      ADDR_W'(OFF_CNT):  rd_mux = DATA_W'(cnt_w);
      default:           rd_mux = '0;
    endcase
    for (int k = 0; k < int'(NUM_CMP); k++) begin
      if (addr_i == ADDR_W'(OFF_CMP1 + k)) rd_mux = DATA_W'(cmp_q[k]);
    end
  end

  assign rdata_o = rd_i ? rd_mux : '0;
  assign irq_o   = ctrl_q[C_EN] && (|(stat_q & ien_q));
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [DATA_W-1:0] ctrl_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  cmp1_i,
  input logic              step_i,
  input logic [5:0]        stat_i,
  input logic              irq_i
);
  localparam logic [DATA_W-1:0] VOID_M = DATA_W'(32'h0000_FC14);

  logic en, frr;
  assign en  = ctrl_i[0];
  assign frr = ctrl_i[9];

  p_ctrl_void_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i & VOID_M) == '0);

  p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wr_i) |=> $stable(cnt_i));

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((stat_i & $past(stat_i)) == $past(stat_i)));

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !irq_i);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !frr && step_i && (cnt_i == cmp1_i) && !wr_i) |=> (cnt_i == '0));

  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && frr && step_i && (&cnt_i) && !wr_i) |=> (stat_i[5] && cnt_i == '0));

  p_cap_flags_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[4:3] == 2'b00);
endmodule

bind gp_timer gp_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_i   (wr_i),
  .ctrl_i (ctrl_q),
  .cnt_i  (cnt_w),
  .cmp1_i (cmp_q[0]),
  .step_i (step_eff),
  .stat_i (stat_q),
  .irq_i  (irq_o)
);

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
  localparam int unsigned CW = 8;
  localparam logic [31:0] ALL = 32'h0000_00FF;
  localparam logic [31:0] EN = 32'h1, ENMOD = 32'h2, FRR = 32'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        t_bus = 1'b0, t_fast = 1'b0, t_slow = 1'b0;
  logic        irq;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gp_timer #(.DATA_W(32), .CNT_W(CW), .PRE_W(12), .ADDR_W(4)) u_gp_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tick_bus_i(t_bus), .tick_fast_i(t_fast),
    .tick_slow_i(t_slow), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd = 1'b1; addr = a; #1; v = rdata; rd = 1'b0;
    check(tag, v, exp);
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t_bus = (src == 0); t_fast = (src == 1); t_slow = (src == 2);
    end
    @(negedge clk); t_bus = 1'b0; t_fast = 1'b0; t_slow = 1'b0;
  endtask

  function automatic int src_of(input int sel);
    if (sel >= 4) return 2;
    if (sel == 1) return 0;
    if (sel == 2) return 1;
    return -1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12: reset values and map
    for (int a = 0; a < 16; a++) begin
      logic [31:0] e;
      e = (a >= 4 && a <= 6) ? ALL : 32'h0;
      chk_reg("R1 reset map", 4'(a), e);
    end
    check("R6 irq after reset", {31'b0, irq}, 32'h0);

    // R2, R3, R6, R11
    wr_reg(4'd1, 32'hFFFF_F123);
    chk_reg("R3 prescaler mask", 4'd1, 32'h123);
    wr_reg(4'd3, 32'hFFFF_FFFF);
    chk_reg("R6 ien mask", 4'd3, 32'h3F);
    wr_reg(4'd5, 32'h40);
    wr_reg(4'd0, 32'hFFFF_7FFF);
    chk_reg("R2 ctrl void bits", 4'd0, 32'hFFFF_03EB);
    wr_reg(4'd0, 32'hFFFF_FFFF);
    chk_reg("R11 ctrl preserved", 4'd0, 32'h0003_01EB);
    chk_reg("R11 prescaler cleared", 4'd1, 32'h0);
    chk_reg("R11 ien cleared", 4'd3, 32'h0);
    chk_reg("R11 cmp2 reset", 4'd5, ALL);
    chk_reg("R11 status cleared", 4'd2, 32'h0);
    wr_reg(4'd0, 32'h0);

    // R3 / R4: select x source x prescale sweep
    for (int sel = 0; sel < 8; sel++) begin
      for (int p = 0; p < 3; p++) begin
        wr_reg(4'd0, 32'h0);
        wr_reg(4'd1, 32'(p));
        for (int s = 0; s < 3; s++) begin
          int e;
          wr_reg(4'd0, 32'h0);
          wr_reg(4'd0, EN | ENMOD | FRR | 32'(sel << 6));
          pulse(s, 12);
          e = (src_of(sel) == s) ? 12 / (p + 1) : 0;
          chk_reg($sformatf("R4 R3 sel=%0d pre=%0d src=%0d", sel, p, s), 4'd9, 32'(e));
        end
      end
    end

    // R10: freeze and resume
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd1, 32'h0);
    wr_reg(4'd0, EN | ENMOD | FRR | 32'h40);
    pulse(0, 7);
    chk_reg("R10 counting", 4'd9, 32'd7);
    wr_reg(4'd0, FRR | 32'h40);
    pulse(0, 5);
    chk_reg("R10 frozen while disabled", 4'd9, 32'd7);
    wr_reg(4'd0, EN | FRR | 32'h40);
    pulse(0, 3);
    chk_reg("R10 resume without enmod", 4'd9, 32'd10);
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd0, EN | ENMOD | FRR | 32'h40);
    chk_reg("R10 enmod clears", 4'd9, 32'd0);

    // R8: restart mode
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd4, 32'd5);
    wr_reg(4'd0, EN | ENMOD | 32'h40);
    for (int i = 1; i <= 13; i++) begin
      pulse(0, 1);
      chk_reg($sformatf("R8 restart step %0d", i), 4'd9, 32'(i % 6));
    end
    chk_reg("R7 OF1 flag in restart", 4'd2, 32'h01);
    pulse(0, 3);
    chk_reg("R8 before cmp1 write", 4'd9, 32'd4);
    wr_reg(4'd4, 32'd5);
    chk_reg("R8 cmp1 write restarts", 4'd9, 32'd0);

    // R5 / R6 / R7
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd2, 32'h3F);
    chk_reg("R5 clear all", 4'd2, 32'h0);
    wr_reg(4'd0, FRR);
    wr_reg(4'd4, 32'd10);
    wr_reg(4'd5, 32'd20);
    wr_reg(4'd6, 32'd30);
    wr_reg(4'd3, 32'h0);
    wr_reg(4'd0, FRR | EN | ENMOD | 32'h40);
    pulse(0, 10);
    chk_reg("R7 OF1", 4'd2, 32'h01);
    pulse(0, 10);
    chk_reg("R7 OF2", 4'd2, 32'h03);
    pulse(0, 10);
    chk_reg("R7 OF3", 4'd2, 32'h07);
    check("R6 masked irq", {31'b0, irq}, 32'h0);
    wr_reg(4'd3, 32'h02);
    check("R6 enabled irq", {31'b0, irq}, 32'h1);
    wr_reg(4'd2, 32'h0);
    chk_reg("R5 write zero no effect", 4'd2, 32'h07);
    wr_reg(4'd2, 32'h02);
    chk_reg("R5 w1c", 4'd2, 32'h05);
    check("R6 irq drops", {31'b0, irq}, 32'h0);
    wr_reg(4'd5, 32'd40);
    pulse(0, 9);
    chk_reg("R7 count before collision", 4'd9, 32'd39);
    @(negedge clk); addr = 4'd2; wdata = 32'h02; wr = 1'b1; t_bus = 1'b1;
    @(negedge clk); wr = 1'b0; t_bus = 1'b0;
    chk_reg("R5 set beats clear", 4'd2, 32'h07);
    check("R6 irq from set", {31'b0, irq}, 32'h1);
    wr_reg(4'd0, FRR | 32'h40);
    check("R6 irq gated by enable", {31'b0, irq}, 32'h0);
    chk_reg("R5 flags survive disable", 4'd2, 32'h07);

    // R9: rollover
    wr_reg(4'd2, 32'h3F);
    wr_reg(4'd3, 32'h0);
    wr_reg(4'd0, FRR | EN | ENMOD | 32'h40);
    pulse(0, 255);
    chk_reg("R9 at top", 4'd9, ALL);
    chk_reg("R9 no rollover yet", 4'd2, 32'h07);
    pulse(0, 1);
    chk_reg("R9 wrapped", 4'd9, 32'h0);
    chk_reg("R9 rollover flag", 4'd2, 32'h27);
    wr_reg(4'd3, 32'h20);
    check("R9 rollover irq", {31'b0, irq}, 32'h1);
    chk_reg("R12 capture1", 4'd7, 32'h0);
    chk_reg("R12 capture2", 4'd8, 32'h0);

    finish_run();
  end
endmodule